// File: doc/BRIEF.md
# Raster-Op Rectangle Copy Engine

This block moves a rectangle of bytes inside a small frame memory. Every destination byte is replaced by a Boolean function of its own old value and the matching source byte. Software describes the copy by writing a few configuration registers: width in bytes, height in rows, source and destination start addresses, source and destination pitches, a mode byte and an 8-bit raster-operation code. A write to the go register then launches the copy. The engine reports progress on a `busy` line and a sticky `done` flag.

The engine reaches the frame memory through a single-port byte interface with one cycle of read latency. Each byte takes three cycles: the source is read, then the destination is read, then the destination is written. The copy can walk forward, with addresses rising, or backward, with addresses falling and both pitches negated. Choosing the direction lets software copy overlapping rectangles without corrupting source bytes before they are read.

Top module: `rop_blit`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done` and `mem_we` are all low.
- R2: Sixteen operation codes are accepted, with `s` the source byte and `d` the old destination byte:
  - 0x00 gives 0.
  - 0x05 gives s&d.
  - 0x06 gives d.
  - 0x09 gives s&~d.
  - 0x0B gives ~d.
  - 0x0D gives s.
  - 0x0E gives 0xFF.
  - 0x50 gives ~s&d.
  - 0x59 gives s^d.
  - 0x6D gives s|d.
  - 0x90 gives ~s|~d.
  - 0x95 gives ~(s^d).
  - 0xAD gives s|~d.
  - 0xD0 gives ~s.
  - 0xD6 gives ~s|d.
  - 0xDA gives ~s&~d.
- R3: Code 0x06 leaves every destination byte unchanged, and code 0x0E writes 0xFF to every destination byte.
- R4: With mode bit 0 clear, byte x of row y reads from source address SRC+y*SP+x and writes to DST+y*DP+x. Addresses wrap modulo the memory size. Rows are processed in ascending order, and bytes within a row in ascending x.
- R5: With mode bit 0 set, byte x of row y uses SRC−y*SP−x and DST−y*DP−x. The start addresses therefore name the highest byte of each rectangle.
- R6: Each byte's source and destination are read before that byte is written. The result of an overlapping copy therefore equals a sequential byte-by-byte model that runs in the selected direction.
- R7: Starting with any other operation code writes nothing to memory. `busy` stays low, and `done` is high in the cycle after the go write.
- R8: A go write while `busy` is high is ignored. Register writes made during a copy do not change the copy in progress.
- R9: A width or height of zero behaves like R7: no writes, `busy` stays low, and `done` is set.
- R10: A valid copy keeps `busy` high for exactly 3·W·H cycles. `done` rises in the cycle after the last write, and the go write that launches a copy clears `done`.
- R11: The pixel-width field, mode bits 2:1, has no effect on the result, because the width is always counted in bytes.
- R12: Register select codes are: 0 width, 1 height, 2 source address, 3 destination address, 4 source pitch, 5 destination pitch, 6 mode, 7 operation code, 8 go.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register select (R12) |
| reg_wdata | input | RW | Register write data |
| busy | output | 1 | High while a copy runs |
| done | output | 1 | Sticky completion flag |
| mem_addr | output | AW | Frame memory byte address |
| mem_we | output | 1 | Frame memory write enable |
| mem_wdata | output | 8 | Frame memory write data |
| mem_rdata | input | 8 | Frame memory read data, one cycle after the address |

## Verification
A go write takes effect at the clock edge where it is sampled. For a valid copy, `busy` is seen high from the next falling edge onward. The bench counts busy cycles at falling edges and expects exactly 3·W·H of them. It then expects `done` at the first falling edge after `busy` drops. For a rejected start (R7, R9), the bench checks `done` and `busy` at the very next falling edge. In every case the bench compares the whole memory with its own sequential model only after `done` is seen, so no byte is inspected before its write cycle has completed.

// File: rtl/rop_blit_pkg.sv
// Shared definitions for the raster-op rectangle copy engine.
// Assumes byte-wide data; the operation table is fixed by the requirements.
package rop_blit_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SRC  = 2'd1,
        ST_DST  = 2'd2,
        ST_WR   = 2'd3
    } walk_state_t;

    localparam logic [3:0] SEL_WIDTH  = 4'd0;
    localparam logic [3:0] SEL_HEIGHT = 4'd1;
    localparam logic [3:0] SEL_SRC    = 4'd2;
    localparam logic [3:0] SEL_DST    = 4'd3;
    localparam logic [3:0] SEL_SPITCH = 4'd4;
    localparam logic [3:0] SEL_DPITCH = 4'd5;
    localparam logic [3:0] SEL_MODE   = 4'd6;
    localparam logic [3:0] SEL_OPCODE = 4'd7;
    localparam logic [3:0] SEL_GO     = 4'd8;

    localparam logic [7:0] OP_KEEP = 8'h06;

    typedef struct packed {
        logic       ok;
        logic [7:0] val;
    } op_out_t;

    // Evaluates one raster operation on a source/destination byte pair.
    function automatic op_out_t op_eval(input logic [7:0] code,
                                        input logic [7:0] s,
                                        input logic [7:0] d);
        op_out_t r;
        r.ok = 1'b1;
        case (code)
            8'h00:   r.val = 8'h00;
            8'h05:   r.val = s & d;
            8'h06:   r.val = d;
            8'h09:   r.val = s & ~d;
            8'h0B:   r.val = ~d;
            8'h0D:   r.val = s;
            8'h0E:   r.val = 8'hFF;
            8'h50:   r.val = ~s & d;
            8'h59:   r.val = s ^ d;
            8'h6D:   r.val = s | d;
            8'h90:   r.val = ~s | ~d;
            8'h95:   r.val = ~(s ^ d);
            8'hAD:   r.val = s | ~d;
            8'hD0:   r.val = ~s;
            8'hD6:   r.val = ~s | d;
            8'hDA:   r.val = ~s & ~d;
            default: begin
                r.ok  = 1'b0;
                r.val = d;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rop_blit_regs.sv
// Configuration register file for the copy engine.
// Holds the rectangle description and turns a go write into a one-cycle
// request. Values are truncated to the parameter widths; no read-back.
module rop_blit_regs
    import rop_blit_pkg::*;
#(
    parameter int AW = 12,
    parameter int LW = 8,
    parameter int RW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [3:0]    reg_sel,
    input  logic [RW-1:0] reg_wdata,
    output logic [LW-1:0] cfg_width,
    output logic [LW-1:0] cfg_height,
    output logic [AW-1:0] cfg_src,
    output logic [AW-1:0] cfg_dst,
    output logic [AW-1:0] cfg_spitch,
    output logic [AW-1:0] cfg_dpitch,
    output logic          cfg_backward,
    output logic [7:0]    cfg_opcode,
    output logic          go_req
);

    // Go request is a pure decode of the write strobe.
    assign go_req = reg_wr && (reg_sel == SEL_GO);

    // Capture configuration writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_width    <= '0;
            cfg_height   <= '0;
            cfg_src      <= '0;
            cfg_dst      <= '0;
            cfg_spitch   <= '0;
            cfg_dpitch   <= '0;
            cfg_backward <= 1'b0;
            cfg_opcode   <= '0;
        end else if (reg_wr) begin
            case (reg_sel)
                SEL_WIDTH:  cfg_width    <= LW'(reg_wdata);
                SEL_HEIGHT: cfg_height   <= LW'(reg_wdata);
                SEL_SRC:    cfg_src      <= AW'(reg_wdata);
                SEL_DST:    cfg_dst      <= AW'(reg_wdata);
                SEL_SPITCH: cfg_spitch   <= AW'(reg_wdata);
                SEL_DPITCH: cfg_dpitch   <= AW'(reg_wdata);
                SEL_MODE:   cfg_backward <= reg_wdata[0];
                SEL_OPCODE: cfg_opcode   <= reg_wdata[7:0];
                default:    ;
            endcase
        end
    end

endmodule

// File: rtl/rop_blit_alu.sv
// Byte combiner: applies the latched raster operation to a source byte
// and the old destination byte. Purely combinational.
module rop_blit_alu
    import rop_blit_pkg::*;
(
    input  logic [7:0] op_code,
    input  logic [7:0] src_byte,
    input  logic [7:0] dst_byte,
    output logic [7:0] result
);

    op_out_t ev;

    // Evaluate the selected function.
    always_comb begin
        ev     = op_eval(op_code, src_byte, dst_byte);
        result = ev.val;
    end

    // R3: the keep code must pass the destination through untouched.
    always_comb begin
        a_r3_keep_passes_dst: assert (op_code != OP_KEEP || result == dst_byte)
            else $error("keep code altered destination byte");
    end

endmodule

// File: rtl/rop_blit_walker.sv
// Rectangle walker: latches the rectangle at launch, then steps through
// it byte by byte in three phases (read source, read destination, write).
// Assumes memory read data arrives one cycle after the address.
module rop_blit_walker
    import rop_blit_pkg::*;
#(
    parameter int AW = 12,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_req,
    input  logic [LW-1:0] cfg_width,
    input  logic [LW-1:0] cfg_height,
    input  logic [AW-1:0] cfg_src,
    input  logic [AW-1:0] cfg_dst,
    input  logic [AW-1:0] cfg_spitch,
    input  logic [AW-1:0] cfg_dpitch,
    input  logic          cfg_backward,
    input  logic [7:0]    cfg_opcode,
    output logic [7:0]    alu_code,
    output logic [7:0]    alu_src,
    output logic [7:0]    alu_dst,
    input  logic [7:0]    alu_result,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata,
    output logic          busy,
    output logic          done
);

    walk_state_t   state;
    logic [LW-1:0] col, row, wlen, hlen;
    logic [AW-1:0] srow, drow, sstep, dstep;
    logic          bwd;
    logic [7:0]    code_q, src_q;
    logic          accept, launch_ok, last_col, last_row;
    logic [AW-1:0] s_addr, d_addr;
    op_out_t       chk;

    // Launch qualification from the live configuration.
    always_comb begin
        chk       = op_eval(cfg_opcode, 8'h00, 8'h00);
        accept    = go_req && (state == ST_IDLE);
        launch_ok = chk.ok && (cfg_width != '0) && (cfg_height != '0);
        last_col  = (col == wlen - 1'b1);
        last_row  = (row == hlen - 1'b1);
    end

    // Current byte addresses within the row, walked up or down.
    always_comb begin
        s_addr = bwd ? (srow - AW'(col)) : (srow + AW'(col));
        d_addr = bwd ? (drow - AW'(col)) : (drow + AW'(col));
    end

    // Memory port and combiner hookup.
    always_comb begin
        mem_addr  = (state == ST_SRC) ? s_addr : d_addr;
        mem_we    = (state == ST_WR);
        mem_wdata = alu_result;
        alu_code  = code_q;
        alu_src   = src_q;
        alu_dst   = mem_rdata;
        busy      = (state != ST_IDLE);
    end

    // Sequencer: launch, per-byte phases, row stepping, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            done   <= 1'b0;
            col    <= '0;
            row    <= '0;
            wlen   <= '0;
            hlen   <= '0;
            srow   <= '0;
            drow   <= '0;
            sstep  <= '0;
            dstep  <= '0;
            bwd    <= 1'b0;
            code_q <= '0;
            src_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if (launch_ok) begin
                            state  <= ST_SRC;
                            done   <= 1'b0;
                            col    <= '0;
                            row    <= '0;
                            wlen   <= cfg_width;
                            hlen   <= cfg_height;
                            srow   <= cfg_src;
                            drow   <= cfg_dst;
                            sstep  <= cfg_backward ? (AW'(0) - cfg_spitch) : cfg_spitch;
                            dstep  <= cfg_backward ? (AW'(0) - cfg_dpitch) : cfg_dpitch;
                            bwd    <= cfg_backward;
                            code_q <= cfg_opcode;
                        end else begin
                            done <= 1'b1;
                        end
                    end
                end
                ST_SRC: state <= ST_DST;
                ST_DST: begin
                    src_q <= mem_rdata;
                    state <= ST_WR;
                end
                ST_WR: begin
                    if (last_col) begin
                        col  <= '0;
                        srow <= srow + sstep;
                        drow <= drow + dstep;
                        if (last_row) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else begin
                            row   <= row + 1'b1;
                            state <= ST_SRC;
                        end
                    end else begin
                        col   <= col + 1'b1;
                        state <= ST_SRC;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1/R10: busy and done never overlap.
    a_r10_busy_done_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R10: writes only happen during a copy.
    a_r10_write_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R6: at most one write per byte slot, never back-to-back.
    a_r6_write_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R7: a rejected code ends at once with no copy.
    a_r7_bad_code_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !chk.ok) |=> (done && !busy));

    // R9: an empty rectangle ends at once with no copy.
    a_r9_empty_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (cfg_width == '0 || cfg_height == '0)) |=> (done && !busy));

    // R8: a go write during a copy leaves the latched copy intact.
    a_r8_go_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (go_req && busy) |=> ($stable(wlen) && $stable(hlen) && $stable(code_q) && $stable(bwd)));

endmodule

// File: rtl/rop_blit.sv
// Top of the raster-op rectangle copy engine: register file, walker and
// byte combiner. Frame memory lives outside, on a single-port byte bus.
module rop_blit #(
    parameter int AW = 12,
    parameter int LW = 8,
    parameter int RW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [3:0]    reg_sel,
    input  logic [RW-1:0] reg_wdata,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata
);

    logic [LW-1:0] cfg_width, cfg_height;
    logic [AW-1:0] cfg_src, cfg_dst, cfg_spitch, cfg_dpitch;
    logic          cfg_backward, go_req;
    logic [7:0]    cfg_opcode, alu_code, alu_src, alu_dst, alu_result;

    rop_blit_regs #(.AW(AW), .LW(LW), .RW(RW)) regs_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .cfg_width(cfg_width), .cfg_height(cfg_height),
        .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_spitch(cfg_spitch),
        .cfg_dpitch(cfg_dpitch), .cfg_backward(cfg_backward),
        .cfg_opcode(cfg_opcode), .go_req(go_req)
    );

    rop_blit_walker #(.AW(AW), .LW(LW)) walk_i (
        .clk(clk), .rst_n(rst_n), .go_req(go_req),
        .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_src(cfg_src),
        .cfg_dst(cfg_dst), .cfg_spitch(cfg_spitch), .cfg_dpitch(cfg_dpitch),
        .cfg_backward(cfg_backward), .cfg_opcode(cfg_opcode),
        .alu_code(alu_code), .alu_src(alu_src), .alu_dst(alu_dst),
        .alu_result(alu_result), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .done(done)
    );

    rop_blit_alu alu_i (
        .op_code(alu_code), .src_byte(alu_src), .dst_byte(alu_dst),
        .result(alu_result)
    );

endmodule

// File: tb/rop_blit_tb_top.sv
// Self-checking bench: external byte memory, sequential reference model,
// directed corner cases plus seeded random rectangles.
module rop_blit_tb_top;

    localparam int AW    = 12;
    localparam int LW    = 8;
    localparam int RW    = 16;
    localparam int MSIZE = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [3:0]    reg_sel = '0;
    logic [RW-1:0] reg_wdata = '0;
    logic          busy, done, mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata = '0;

    logic [7:0] mem   [MSIZE];
    logic [7:0] model [MSIZE];

    int checks = 0;
    int bad = 0;
    int busy_cnt = 0;
    int we_cnt = 0;
    int cyc = 0;
    bit finished = 0;

    byte unsigned codes [16] = '{8'h00, 8'h05, 8'h06, 8'h09, 8'h0B, 8'h0D, 8'h0E, 8'h50,
                                 8'h59, 8'h6D, 8'h90, 8'h95, 8'hAD, 8'hD0, 8'hD6, 8'hDA};

    rop_blit #(.AW(AW), .LW(LW), .RW(RW)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .busy(busy), .done(done), .mem_addr(mem_addr),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (busy)   busy_cnt <= busy_cnt + 1;
        if (mem_we) we_cnt   <= we_cnt + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_op(input logic [7:0] c, input logic [7:0] s, input logic [7:0] d);
        case (c)
            8'h00: return 8'h00;
            8'h05: return d & s;
            8'h06: return d;
            8'h09: return s & ~d;
            8'h0B: return ~d;
            8'h0D: return s;
            8'h0E: return 8'hFF;
            8'h50: return d & ~s;
            8'h59: return d ^ s;
            8'h6D: return d | s;
            8'h90: return ~(s & d);
            8'h95: return ~(d ^ s);
            8'hAD: return ~d | s;
            8'hD0: return ~s;
            8'hD6: return d | ~s;
            8'hDA: return ~(s | d);
            default: return d;
        endcase
    endfunction

    task automatic wr(input logic [3:0] sel, input int val);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = RW'(val);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic model_copy(input int w, input int h, input int s, input int d,
                              input int sp, input int dp, input bit bwd, input logic [7:0] c);
        for (int y = 0; y < h; y++) begin
            for (int x = 0; x < w; x++) begin
                int sa, da;
                sa = bwd ? (s - y*sp - x) : (s + y*sp + x);
                da = bwd ? (d - y*dp - x) : (d + y*dp + x);
                sa = sa & (MSIZE-1);
                da = da & (MSIZE-1);
                model[da] = ref_op(c, model[sa], model[da]);
            end
        end
    endtask

    function automatic int mem_diff();
        int n = 0;
        for (int i = 0; i < MSIZE; i++) if (mem[i] !== model[i]) n++;
        return n;
    endfunction

    task automatic setup(input int w, input int h, input int s, input int d,
                         input int sp, input int dp, input int mode, input logic [7:0] c);
        wr(4'd0, w); wr(4'd1, h); wr(4'd2, s); wr(4'd3, d);
        wr(4'd4, sp); wr(4'd5, dp); wr(4'd6, mode); wr(4'd7, c);
    endtask

    task automatic wait_done(input string req);
        int t = 0;
        while (!done && t < 20000) begin @(negedge clk); t++; end
        check(t < 20000, req, t, 0);
    endtask

    // Full valid copy with memory, duration and done checks.
    task automatic run(input string req, input int w, input int h, input int s, input int d,
                       input int sp, input int dp, input int mode, input logic [7:0] c);
        setup(w, h, s, d, sp, dp, mode, c);
        model_copy(w, h, s, d, sp, dp, mode[0], c);
        busy_cnt = 0;
        wr(4'd8, 1);
        wait_done(req);
        check(busy_cnt == 3*w*h, "R10 busy cycles", busy_cnt, 3*w*h);
        check(mem_diff() == 0, req, mem_diff(), 0);
    endtask

    // Rejected start: nothing written, done next cycle, busy low.
    task automatic run_reject(input string req, input int w, input int h, input logic [7:0] c);
        setup(w, h, 16, 32, 8, 8, 0, c);
        busy_cnt = 0; we_cnt = 0;
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 4'd8; reg_wdata = 1;
        @(negedge clk);
        reg_wr = 1'b0;
        check(done === 1'b1 && busy === 1'b0, req, {done, busy}, 2);
        repeat (4) @(negedge clk);
        check(we_cnt == 0 && busy_cnt == 0, req, we_cnt + busy_cnt, 0);
        check(mem_diff() == 0, req, mem_diff(), 0);
    endtask

    initial begin
        void'($urandom(32'd20240605));
        for (int i = 0; i < MSIZE; i++) begin
            mem[i] = 8'($urandom);
            model[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(busy === 1'b0 && done === 1'b0 && mem_we === 1'b0, "R1 reset", {busy, done, mem_we}, 0);

        // R3: keep and all-ones codes
        run("R3 keep", 6, 3, 100, 400, 16, 16, 0, 8'h06);
        run("R3 ones", 6, 3, 100, 400, 16, 16, 0, 8'h0E);

        // R2 R4 R5 R6: every code in both directions on overlapping rectangles
        for (int k = 0; k < 16; k++) begin
            run("R2 R4 R6 fwd overlap", 5, 3, 600 + k*40, 602 + k*40, 9, 9, 0, codes[k]);
            run("R2 R5 R6 bwd overlap", 5, 3, 1600 + k*40, 1603 + k*40, 9, 9, 1, codes[k]);
        end

        // R6: classic scroll cases
        run("R6 fwd shift down", 10, 4, 2500, 2480, 20, 20, 0, 8'h0D);
        run("R6 bwd shift up", 10, 4, 2600, 2620, 20, 20, 1, 8'h0D);

        // R4 R5: address wrap at the memory edge
        run("R4 wrap", 8, 2, MSIZE-4, 10, 8, 8, 0, 8'h59);
        run("R5 wrap", 8, 2, 3, 3000, 8, 8, 1, 8'hD6);

        // R11: pixel-width field settings give the same result
        for (int p = 0; p < 4; p++)
            run("R11 pixel field", 7, 2, 200, 900, 11, 13, p << 1, 8'hDA);

        // R7: unknown code; R9: empty rectangle
        run_reject("R7 bad code", 4, 4, 8'h01);
        run_reject("R7 bad code", 4, 4, 8'hFF);
        run_reject("R9 zero width", 0, 4, 8'h0D);
        run_reject("R9 zero height", 4, 0, 8'h0D);

        // R10: a valid go clears done in the next cycle
        setup(3, 1, 10, 50, 4, 4, 0, 8'h6D);
        model_copy(3, 1, 10, 50, 4, 4, 0, 8'h6D);
        busy_cnt = 0;
        wr(4'd8, 1);
        check(done === 1'b0 && busy === 1'b1, "R10 go clears done", {done, busy}, 1);
        wait_done("R10 finish");
        check(mem_diff() == 0, "R10 data", mem_diff(), 0);

        // R8 R12: go and register writes during a copy are ignored
        setup(8, 4, 1200, 1300, 12, 12, 0, 8'h95);
        model_copy(8, 4, 1200, 1300, 12, 12, 0, 8'h95);
        busy_cnt = 0;
        wr(4'd8, 1);
        wr(4'd0, 1); wr(4'd7, 8'h00); wr(4'd6, 1);
        wr(4'd8, 1);
        wait_done("R8 finish");
        check(busy_cnt == 96, "R8 busy cycles", busy_cnt, 96);
        check(mem_diff() == 0, "R8 data", mem_diff(), 0);

        // Random rectangles across R2 R4 R5 R6
        for (int n = 0; n < 40; n++) begin
            int w, h, s, d, sp, dp, md;
            w  = $urandom_range(1, 16);
            h  = $urandom_range(1, 8);
            s  = $urandom_range(0, MSIZE-1);
            d  = $urandom_range(0, MSIZE-1);
            sp = $urandom_range(0, 40);
            dp = $urandom_range(0, 40);
            md = $urandom_range(0, 7);
            run("R2 R4 R5 random", w, h, s, d, sp, dp, md, codes[$urandom_range(0, 15)]);
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        wait (cyc > 190000);
        if (!finished) begin
            check(1'b0, "watchdog", cyc, 0);
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule